// File: doc/BRIEF.md
# Banked Cartridge Mapper with Split-Port RAM

This block sits between a CPU bus and a cartridge ROM and maps a 4 KiB address window onto a larger ROM made of 2 KiB slices. The window has two halves, and address bit 11 picks between them. The lower half shows whichever ROM slice was last selected. One slice number is special: the highest slice number does not show ROM. Selecting it puts a 1 KiB RAM into the lower half instead. That RAM has separate write-only and read-only address ranges.

The upper half always shows the highest ROM slice, with one exception. A 256-byte RAM window sits at its start, also split into a write page and a read page. This window shows one of four 256-byte RAM banks.

The selections change through hot-spot addresses near the top of the window. Any read or write there updates the selection register, and the new selection applies from the next access. The bus has no separate read strobe on the RAM. As a result, a read that lands on a write page also stores the current data-bus value into the addressed RAM byte.

Top module: `cart_slice_mapper`

## Requirements
- R1: After reset, the lower half selects ROM slice 0 and the RAM window selects bank 0.
- R2: When the lower half holds ordinary slice s, a read at window offset A drives rom_addr = {s, A[10:0]} and returns rom_data on cpu_rdata.
- R3: At offsets 0xA00 to 0xFFF, rom_addr = {NUM_SLICES-1, A[10:0]} and a read returns rom_data, whatever slice the lower half holds.
- R4: A read or a write at offset 0xFE0+k, with k < NUM_SLICES, selects slice k for the lower half from the next access on. The hot-spot access itself is served from the highest slice. Accesses at other offsets leave both selections unchanged.
- R5: While slice NUM_SLICES-1 is selected, a write at offset A in 0x000 to 0x3FF stores the byte at RAM location A[9:0]. A read at offset A in 0x400 to 0x7FF returns RAM location A[9:0].
- R6: A write at offset 0x800 to 0x8FF stores into RAM location 0x400 + bank*256 + A[7:0]. A read at 0x900 to 0x9FF returns that same location.
- R7: A read or a write at offset 0xFE8+b, with b from 0 to 3, selects RAM bank b from the next access on. The four banks hold separate data.
- R8: A read at a write-page offset returns the previous contents of the addressed RAM byte. The same read then stores cpu_wdata into that byte.
- R9: Writes to read pages and to ROM-mapped offsets leave all RAM contents unchanged.
- R10: cpu_rdata is 0 in any cycle without cpu_rd.
- R11: Only cpu_addr[11:0] is decoded. Higher address bits have no effect on mapping or hot spots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Read access this cycle |
| cpu_wr | input | 1 | Write access this cycle |
| cpu_addr | input | ADDR_W (16) | CPU address; bits above 11 ignored |
| cpu_wdata | input | 8 | Data-bus value during the access |
| cpu_rdata | output | 8 | Read data, 0 when not reading |
| rom_addr | output | ROM_AW (14) | Byte address into the ROM image |
| rom_data | input | 8 | ROM byte at rom_addr, combinational |

## Verification
The bench targets the edge of each decode range. It probes offsets 0x3FF and 0x400 on the lower RAM, 0x9FF and 0xA00 above the window, and the last slice hot spot. A decoder one address off would return ROM where RAM belongs, or the reverse. It checks that a hot-spot access is itself still served from the highest slice and that the new slice appears only afterwards. It writes distinct values into all four window banks, so a wrong bank offset shows up as aliased data. It reads the write pages to confirm that the spurious store happens and that the old byte is returned. It also writes to read pages and ROM offsets and confirms that nothing changes.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int SEG_AW     = 11;
    localparam int LRAM_AW    = 10;
    localparam int WIN_AW     = 8;
    localparam int RAM_AW     = 11;
    localparam int RAM_BANKS  = 4;
    localparam int BANK_W     = $clog2(RAM_BANKS);
    localparam int OFF_W      = 12;

    localparam logic [OFF_W-1:0] SLICE_HOT_BASE = 12'hFE0;
    localparam logic [OFF_W-1:0] BANK_HOT_BASE  = 12'hFE8;

    typedef logic [7:0] byte_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef enum logic [2:0] {
        RG_ROM,
        RG_LRAM_WR,
        RG_LRAM_RD,
        RG_WIN_WR,
        RG_WIN_RD
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [RAM_AW-1:0]   ram_addr;
        logic                wr_page;
        logic                rd_page;
    } map_t;

    function automatic logic in_span(off_t a, off_t lo, off_t cnt);
        return (a >= lo) && (a < lo + cnt);
    endfunction

endpackage

// File: rtl/cart_bank_sel.sv
module cart_bank_sel
    import cart_map_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    localparam int SLICE_W   = $clog2(NUM_SLICES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc,
    input  off_t               off,
    output logic [SLICE_W-1:0] low_slice,
    output logic [BANK_W-1:0]  ram_bank
);

    logic slice_hit;
    logic bank_hit;
    off_t slice_delta;

    always_comb begin
        slice_hit   = acc && in_span(off, SLICE_HOT_BASE, off_t'(NUM_SLICES));
        bank_hit    = acc && in_span(off, BANK_HOT_BASE, off_t'(RAM_BANKS));
        slice_delta = off - SLICE_HOT_BASE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_slice <= '0;
            ram_bank  <= '0;
        end else begin
            if (slice_hit) low_slice <= slice_delta[SLICE_W-1:0];
            if (bank_hit)  ram_bank  <= off[BANK_W-1:0];
        end
    end

endmodule

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_map_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int ROM_AW    = SLICE_W + SEG_AW
) (
    input  off_t               off,
    input  logic [SLICE_W-1:0] low_slice,
    input  logic [BANK_W-1:0]  ram_bank,
    output map_t               map,
    output logic [ROM_AW-1:0]  rom_addr
);

    localparam logic [SLICE_W-1:0] LAST_SLICE = SLICE_W'(NUM_SLICES - 1);

    logic               ram_slice_on;
    logic [SLICE_W-1:0] seg_slice;

    always_comb begin
        ram_slice_on = (low_slice == LAST_SLICE);
        seg_slice    = off[SEG_AW] ? LAST_SLICE : low_slice;
        rom_addr     = {seg_slice, off[SEG_AW-1:0]};

        map.region   = RG_ROM;
        map.ram_addr = '0;
        if (!off[SEG_AW]) begin
            if (ram_slice_on) begin
                map.region   = off[LRAM_AW] ? RG_LRAM_RD : RG_LRAM_WR;
                map.ram_addr = {1'b0, off[LRAM_AW-1:0]};
            end
        end else if (off[SEG_AW-1:WIN_AW+1] == '0) begin
            map.region   = off[WIN_AW] ? RG_WIN_RD : RG_WIN_WR;
            map.ram_addr = {1'b1, ram_bank, off[WIN_AW-1:0]};
        end
        map.wr_page = (map.region == RG_LRAM_WR) || (map.region == RG_WIN_WR);
        map.rd_page = (map.region == RG_LRAM_RD) || (map.region == RG_WIN_RD);
    end

endmodule

// File: rtl/cart_ram.sv
module cart_ram
    import cart_map_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  byte_t             wdata,
    output byte_t             rdata
);

    localparam int DEPTH = 1 << RAM_AW;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/cart_slice_mapper.sv
module cart_slice_mapper
    import cart_map_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    parameter int ADDR_W     = 16,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int ROM_AW    = SLICE_W + SEG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data
);

    off_t               off;
    logic               acc;
    logic [SLICE_W-1:0] low_slice;
    logic [BANK_W-1:0]  ram_bank;
    map_t               map;
    byte_t              ram_q;
    logic               ram_we;
    logic               unused_hi;

    assign off       = cpu_addr[OFF_W-1:0];
    assign unused_hi = ^cpu_addr[ADDR_W-1:OFF_W];
    assign acc       = cpu_rd | cpu_wr;

    cart_bank_sel #(.NUM_SLICES(NUM_SLICES)) i_sel (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .off       (off),
        .low_slice (low_slice),
        .ram_bank  (ram_bank)
    );

    cart_addr_decode #(.NUM_SLICES(NUM_SLICES)) i_dec (
        .off       (off),
        .low_slice (low_slice),
        .ram_bank  (ram_bank),
        .map       (map),
        .rom_addr  (rom_addr)
    );

    // A read on a write page still strobes the RAM with the bus value.
    assign ram_we = acc && map.wr_page;

    cart_ram i_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (map.ram_addr),
        .wdata (cpu_wdata),
        .rdata (ram_q)
    );

    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            cpu_rdata = (map.region == RG_ROM) ? rom_data : ram_q;
        end
    end

endmodule

// File: rtl/cart_map_chk.sv
module cart_map_chk
    import cart_map_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int ROM_AW    = SLICE_W + SEG_AW
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input off_t               off,
    input logic [7:0]         cpu_rdata,
    input logic [ROM_AW-1:0]  rom_addr,
    input logic [SLICE_W-1:0] low_slice,
    input logic [BANK_W-1:0]  ram_bank
);

    logic acc, s_hot, b_hot;
    assign acc   = cpu_rd | cpu_wr;
    assign s_hot = acc && (off >= SLICE_HOT_BASE) && (off < SLICE_HOT_BASE + off_t'(NUM_SLICES));
    assign b_hot = acc && (off >= BANK_HOT_BASE) && (off < BANK_HOT_BASE + off_t'(RAM_BANKS));

    // R1
    reset_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (low_slice == '0) && (ram_bank == '0));

    // R3
    upper_last_slice_chk: assert property (@(posedge clk) disable iff (rst)
        off[SEG_AW] |-> rom_addr[ROM_AW-1:SEG_AW] == SLICE_W'(NUM_SLICES - 1));

    // R4
    slice_hot_chk: assert property (@(posedge clk) disable iff (rst)
        s_hot |=> low_slice == $past(off[SLICE_W-1:0]));

    // R4
    no_hot_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(s_hot || b_hot) |=> $stable(low_slice) && $stable(ram_bank));

    // R7
    bank_hot_chk: assert property (@(posedge clk) disable iff (rst)
        b_hot |=> ram_bank == $past(off[BANK_W-1:0]));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |-> cpu_rdata == 8'h00);

endmodule

bind cart_slice_mapper cart_map_chk #(.NUM_SLICES(NUM_SLICES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .off       (cpu_addr[11:0]),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .low_slice (low_slice),
    .ram_bank  (ram_bank)
);

// File: tb/test_cart_slice_mapper.sv
module test_cart_slice_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int RAW = 14;

    logic clk = 0;
    logic rst = 1;
    logic cpu_rd = 0, cpu_wr = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [RAW-1:0] rom_addr;
    logic [7:0] rom_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] q;
    logic [RAW-1:0] ra;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_byte(logic [RAW-1:0] a);
        return a[7:0] ^ {a[13:11], a[10:8], 2'b01};
    endfunction

    assign rom_data = rom_byte(rom_addr);

    cart_slice_mapper i_cart_slice_mapper (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_data(rom_data)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus(logic rd, logic wr, logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        #1;
        q = cpu_rdata; ra = rom_addr;
        @(posedge clk);
        #1;
        cpu_rd = 0; cpu_wr = 0;
    endtask

    function automatic logic [RAW-1:0] ra_of(int s, logic [15:0] a);
        return {3'(s), a[10:0]};
    endfunction

    task automatic t_reset;
        bus(1, 0, 16'h0005, 8'h00);
        chk("R1 slice0 rom_addr", int'(ra), int'(ra_of(0, 16'h0005)));
        chk("R1 slice0 data", int'(q), int'(rom_byte(ra_of(0, 16'h0005))));
        // bank 0 after reset: write page lands at 0x400 = same as bank0 read page
        bus(0, 1, 16'h0830, 8'h6C);
        bus(1, 0, 16'h0FE8, 8'h00);
        bus(1, 0, 16'h0930, 8'h00);
        chk("R1 bank0 default", int'(q), 8'h6C);
        @(negedge clk); #1;
        chk("R10 idle rdata", int'(cpu_rdata), 0);
    endtask

    task automatic t_low_rom;
        for (int s = 0; s < NS - 1; s++) begin
            bus(s % 2, 1 - (s % 2), 16'h0FE0 + 16'(s), 8'h00);
            chk("R4 hot access from last slice", int'(ra), int'(ra_of(NS - 1, 16'h0FE0 + 16'(s))));
            bus(1, 0, 16'h0123, 8'h00);
            chk("R2 low rom_addr", int'(ra), int'(ra_of(s, 16'h0123)));
            chk("R2 low data", int'(q), int'(rom_byte(ra_of(s, 16'h0123))));
            bus(1, 0, 16'h07FF, 8'h00);
            chk("R2 low top byte", int'(q), int'(rom_byte(ra_of(s, 16'h07FF))));
        end
    endtask

    task automatic t_upper;
        bus(0, 1, 16'h0FE2, 8'h00);
        bus(1, 0, 16'h0A00, 8'h00);
        chk("R3 0xA00", int'(q), int'(rom_byte(ra_of(NS - 1, 16'h0A00))));
        bus(1, 0, 16'h0FFF, 8'h00);
        chk("R3 0xFFF", int'(q), int'(rom_byte(ra_of(NS - 1, 16'h0FFF))));
        bus(1, 0, 16'h0FDF, 8'h00);
        chk("R3 0xFDF", int'(q), int'(rom_byte(ra_of(NS - 1, 16'h0FDF))));
        bus(1, 0, 16'h0456, 8'h00);
        chk("R4 non-hot keeps slice 2", int'(ra), int'(ra_of(2, 16'h0456)));
    endtask

    task automatic t_low_ram;
        bus(1, 0, 16'h0FE7, 8'h00);
        bus(0, 1, 16'h0010, 8'h5A);
        bus(1, 0, 16'h0410, 8'h00);
        chk("R5 ram 0x010", int'(q), 8'h5A);
        bus(0, 1, 16'h03FF, 8'hA7);
        bus(1, 0, 16'h07FF, 8'h00);
        chk("R5 ram 0x3FF", int'(q), 8'hA7);
        bus(0, 1, 16'h0410, 8'hEE);
        bus(1, 0, 16'h0410, 8'h00);
        chk("R9 read page write ignored", int'(q), 8'h5A);
    endtask

    task automatic t_window;
        for (int b = 0; b < 4; b++) begin
            bus(0, 1, 16'h0FE8 + 16'(b), 8'h00);
            bus(0, 1, 16'h0840, 8'(b * 17 + 3));
        end
        for (int b = 3; b >= 0; b--) begin
            bus(1, 0, 16'h0FE8 + 16'(b), 8'h00);
            bus(1, 0, 16'h0940, 8'h00);
            chk("R7 bank data", int'(q), b * 17 + 3);
        end
        bus(0, 1, 16'h08FF, 8'h3D);
        bus(1, 0, 16'h09FF, 8'h00);
        chk("R6 window top", int'(q), 8'h3D);
        bus(1, 0, 16'h0010, 8'h00);
        chk("R6 window separate from low ram", int'(q), 8'h5A);
        bus(0, 1, 16'h0940, 8'hEE);
        bus(1, 0, 16'h0940, 8'h00);
        chk("R9 window read page write ignored", int'(q), 8'h3);
    endtask

    task automatic t_spurious;
        bus(0, 1, 16'h0020, 8'h11);
        bus(1, 0, 16'h0020, 8'hC3);
        chk("R8 low old byte", int'(q), 8'h11);
        bus(1, 0, 16'h0420, 8'h00);
        chk("R8 low stored bus", int'(q), 8'hC3);
        bus(0, 1, 16'h0855, 8'h22);
        bus(1, 0, 16'h0855, 8'h99);
        chk("R8 window old byte", int'(q), 8'h22);
        bus(1, 0, 16'h0955, 8'h00);
        chk("R8 window stored bus", int'(q), 8'h99);
    endtask

    task automatic t_ignore_and_high;
        bus(0, 1, 16'h0C00, 8'h44);
        bus(1, 0, 16'h0C00, 8'h00);
        chk("R9 rom write ignored", int'(q), int'(rom_byte(ra_of(NS - 1, 16'h0C00))));
        bus(1, 0, 16'h0420, 8'h00);
        chk("R9 ram intact after rom write", int'(q), 8'hC3);
        bus(1, 0, 16'hF000 | 16'h0FE3, 8'h00);
        bus(1, 0, 16'hA123, 8'h00);
        chk("R11 high bits ignored", int'(ra), int'(ra_of(3, 16'h0123)));
        chk("R11 data", int'(q), int'(rom_byte(ra_of(3, 16'h0123))));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_low_rom();
        t_upper();
        t_low_ram();
        t_window();
        t_spurious();
        t_ignore_and_high();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule